// File: doc/BRIEF.md
# Windowed Outbound Address Decoder

This block decides whether a processor-side address should be forwarded to a downstream bus. The upper end of the address map, starting at 0xF0000000, is divided into equal 8 MiB windows. Window i starts at 0xF0000000 + i * 8 MiB, so the index is taken directly from address bits 27:23. Two software-written words control forwarding. The enable word holds one bit per window. In the control word, a two-bit field turns forwarding on for all windows together.

Whatever is written to the enable word, the first window (firmware space) and the last window (the bridge's own registers) never forward. A small two-state machine tracks the global switch. `FWD_OFF` is the reset state. A control write whose field holds the on-code moves it to `FWD_ON`. In `FWD_ON`, a control write with any other code moves it back to `FWD_OFF`. A control write in `FWD_OFF` with a non-on code, or in `FWD_ON` with the on-code, leaves the state unchanged.

An address with its valid strobe is decoded in one cycle. The registered hit flag and window index appear on the clock edge after the strobe.

Top module: `wdec_top`

## Requirements
- R1: After reset the hit output is 0, the index output is 0, and both the enable and control words read as zero, so no address is forwarded.
- R2: With an address whose bits 31:28 are 0xF, the window index is address bits 27:23. A hit reports that index on `win_idx`.
- R3: Window 0 (0xF0000000..0xF07FFFFF) and window 31 (0xFF800000..0xFFFFFFFF) never hit, even when their enable bits (bit 0 and bit 31) are written as 1.
- R4: Forwarding is globally on only when control bits 8:7 hold binary 01. The codes 00, 10 and 11 turn it off.
- R5: Window i hits only if bit i of the enable word is 1.
- R6: `hit` and `win_idx` are registered and show the decode of the address sampled with `addr_valid` on the previous rising edge. A cycle without the strobe gives `hit` = 0 on the next edge.
- R7: An address whose bits 31:28 are not 0xF never hits.
- R8: A register write takes effect for strobes on later edges. A strobe sampled on the same edge as a write is decoded with the settings from before that write.
- R9: Whenever `hit` is 0, `win_idx` is 0.
- R10: `reg_sel` = 0 writes the enable word and `reg_sel` = 1 writes the control word. Control bits other than 8:7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = enable word, 1 = control word |
| reg_wdata | input | 32 | Register write data |
| addr_valid | input | 1 | Address strobe |
| addr | input | 32 | Processor-side address |
| hit | output | 1 | Address falls in an enabled forwarding window |
| win_idx | output | 5 | Index of the hit window, 0 when there is no hit |

## Verification
The assertions check on every cycle several properties of the registered outputs. A hit never names window 0 or window 31. A hit always follows a strobe whose address carried the 0xF region tag, and it reports that address's bits 27:23. The index is zero whenever there is no hit. Each control write also lands the state machine in the state its code selects.

Only the bench's scenarios can show the following behaviours:
- the exact combination of enable bit and global switch that produces a hit;
- that ignored control bits really change nothing;
- that a strobe on the same edge as a write still sees the old settings.

// File: rtl/wdec_pkg.sv
`timescale 1ns/1ps
package wdec_pkg;
    typedef enum logic {FWD_OFF = 1'b0, FWD_ON = 1'b1} fwd_state_t;
    localparam logic [1:0] CTRL_CODE_ON = 2'b01;
endpackage

// File: rtl/wdec_cfg.sv
`timescale 1ns/1ps
module wdec_cfg
    import wdec_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_WIN  = 32,
    parameter int CTRL_LSB = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_sel,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [NUM_WIN-1:0] win_en,
    output logic               fwd_on
);
    localparam logic [NUM_WIN-1:0] EDGE_BITS =
        (NUM_WIN'(1) << (NUM_WIN - 1)) | NUM_WIN'(1);
    localparam logic [NUM_WIN-1:0] KEEP_MASK = ~EDGE_BITS;

    fwd_state_t st_q, st_d;
    logic [1:0] code;
    logic       ctrl_wr;

    assign code    = reg_wdata[CTRL_LSB +: 2];
    assign ctrl_wr = reg_wr && reg_sel;

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            unique case (st_q)
                FWD_OFF: if (code == CTRL_CODE_ON) st_d = FWD_ON;
                FWD_ON:  if (code != CTRL_CODE_ON) st_d = FWD_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FWD_OFF;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        fwd_on = (st_q == FWD_ON);
    end

    // per-window enable word, edge windows cleared on write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            win_en <= '0;
        else if (reg_wr && !reg_sel)
            win_en <= reg_wdata[NUM_WIN-1:0] & KEEP_MASK;
    end

    assert_ctrl_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && code != CTRL_CODE_ON) |=> !fwd_on);
    assert_ctrl_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && code == CTRL_CODE_ON) |=> fwd_on);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(fwd_on));
endmodule

// File: rtl/wdec_match.sv
`timescale 1ns/1ps
module wdec_match #(
    parameter int ADDR_W    = 32,
    parameter int WIN_LOG2  = 5,
    parameter int WIN_SHIFT = 23
) (
    input  logic                  fwd_on,
    input  logic [(1<<WIN_LOG2)-1:0] win_en,
    input  logic [ADDR_W-1:0]     addr,
    output logic                  match,
    output logic [WIN_LOG2-1:0]   idx
);
    localparam int TAG_W = ADDR_W - WIN_SHIFT - WIN_LOG2;

    logic [TAG_W-1:0] tag;

    always_comb begin
        tag   = addr[ADDR_W-1 -: TAG_W];
        idx   = addr[WIN_SHIFT +: WIN_LOG2];
        match = fwd_on && (tag == {TAG_W{1'b1}}) && win_en[idx];
    end
endmodule

// File: rtl/wdec_top.sv
`timescale 1ns/1ps
module wdec_top #(
    parameter int ADDR_W    = 32,
    parameter int WIN_LOG2  = 5,
    parameter int WIN_SHIFT = 23,
    parameter int CTRL_LSB  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_sel,
    input  logic [ADDR_W-1:0]   reg_wdata,
    input  logic                addr_valid,
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output logic [WIN_LOG2-1:0] win_idx
);
    localparam int NUM_WIN = 1 << WIN_LOG2;
    localparam int TAG_W   = ADDR_W - WIN_SHIFT - WIN_LOG2;

    logic [NUM_WIN-1:0]  win_en;
    logic                fwd_on;
    logic                match;
    logic [WIN_LOG2-1:0] idx;

    wdec_cfg #(
        .DATA_W  (ADDR_W),
        .NUM_WIN (NUM_WIN),
        .CTRL_LSB(CTRL_LSB)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .win_en   (win_en),
        .fwd_on   (fwd_on)
    );

    wdec_match #(
        .ADDR_W   (ADDR_W),
        .WIN_LOG2 (WIN_LOG2),
        .WIN_SHIFT(WIN_SHIFT)
    ) match_i (
        .fwd_on(fwd_on),
        .win_en(win_en),
        .addr  (addr),
        .match (match),
        .idx   (idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            win_idx <= '0;
        end else begin
            hit     <= addr_valid && match;
            win_idx <= (addr_valid && match) ? idx : '0;
        end
    end

    assert_edge_win_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (win_idx != '0 && win_idx != WIN_LOG2'(NUM_WIN - 1)));
    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(addr_valid));
    assert_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(addr[ADDR_W-1 -: TAG_W]) == {TAG_W{1'b1}}));
    assert_idx_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (win_idx == $past(addr[WIN_SHIFT +: WIN_LOG2])));
    assert_idx_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (win_idx == '0));
endmodule

// File: tb/wdec_top_tb_top.sv
`timescale 1ns/1ps
module wdec_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        addr_valid = 1'b0;
    logic [31:0] addr = '0;
    logic        hit;
    logic [4:0]  win_idx;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] en_m = '0;
    logic [31:0] ctrl_m = '0;

    always #2.5 clk = ~clk;

    wdec_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .addr_valid(addr_valid), .addr(addr),
        .hit(hit), .win_idx(win_idx)
    );

    function automatic bit exp_hit(logic [31:0] a);
        logic [4:0] w;
        w = a[27:23];
        return (a[31:28] == 4'hF) && (ctrl_m[8:7] == 2'b01) &&
               (w != 5'd0) && (w != 5'd31) && en_m[w];
    endfunction

    function automatic logic [4:0] exp_idx(logic [31:0] a);
        return exp_hit(a) ? a[27:23] : 5'd0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(bit sel, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (sel) ctrl_m = d; else en_m = d;
    endtask

    task automatic probe(string req, logic [31:0] a);
        logic       eh;
        logic [4:0] ei;
        @(negedge clk);
        addr_valid = 1'b1; addr = a;
        eh = exp_hit(a); ei = exp_idx(a);
        @(negedge clk);
        addr_valid = 1'b0;
        check(req, {31'd0, hit}, {31'd0, eh});
        check(req, {27'd0, win_idx}, {27'd0, ei});
    endtask

    // write and strobe on the same edge: old settings apply (R8)
    task automatic probe_with_wr(bit sel, logic [31:0] d, logic [31:0] a);
        logic eh;
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        addr_valid = 1'b1; addr = a;
        eh = exp_hit(a);
        @(negedge clk);
        reg_wr = 1'b0; addr_valid = 1'b0;
        if (sel) ctrl_m = d; else en_m = d;
        check("R8 same-edge", {31'd0, hit}, {31'd0, eh});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 hit", {31'd0, hit}, 32'd0);
        check("R1 idx", {27'd0, win_idx}, 32'd0);
        probe("R1 nothing forwarded", 32'hF080_0000);

        wr(1'b0, 32'hFFFF_FFFF);
        wr(1'b1, 32'h0000_0080);
        probe("R2 window 1", 32'hF080_0000);
        probe("R2 window 30", 32'hFF7F_FFFF);
        probe("R2 window 17", 32'hF8AB_CDEF);
        probe("R3 window 0", 32'hF000_0000);
        probe("R3 window 31", 32'hFF80_0000);
        probe("R7 below region", 32'hEFFF_FFFF);
        probe("R7 other tag", 32'h7080_0000);
        // R6: idle cycle gives no hit
        @(negedge clk);
        check("R6 no strobe", {31'd0, hit}, 32'd0);
        check("R9 idx idle", {27'd0, win_idx}, 32'd0);

        // R4 control codes
        wr(1'b1, 32'h0000_0000); probe("R4 code 00", 32'hF280_0000);
        wr(1'b1, 32'h0000_0100); probe("R4 code 10", 32'hF280_0000);
        wr(1'b1, 32'h0000_0180); probe("R4 code 11", 32'hF280_0000);
        // R10 other control bits ignored
        wr(1'b1, 32'hFFFF_FEFF); probe("R10 code 01 with noise", 32'hF280_0000);
        wr(1'b1, 32'h0000_0080); probe("R10 code 01 clean", 32'hF280_0000);

        // R5 single window enable
        wr(1'b0, 32'h0000_0080);
        probe("R5 window 7 on", 32'hF380_0004);
        probe("R5 window 8 off", 32'hF400_0000);
        wr(1'b0, 32'h8000_0001);
        probe("R3 bit0 set", 32'hF000_1000);
        probe("R3 bit31 set", 32'hFFFF_FFFC);

        // R8 same-edge write uses old settings
        wr(1'b0, 32'h7FFF_FFFE);
        probe_with_wr(1'b1, 32'h0000_0000, 32'hF180_0000);
        probe("R8 after write", 32'hF180_0000);
        probe_with_wr(1'b1, 32'h0000_0080, 32'hF180_0000);
        probe("R8 after enable", 32'hF180_0000);

        // constrained random
        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            r = $urandom % 8;
            if (r == 0) begin
                wr(1'b0, $urandom);
            end else if (r == 1) begin
                logic [31:0] d;
                d = $urandom;
                if ($urandom % 2) d[8:7] = 2'b01;
                wr(1'b1, d);
            end else begin
                logic [31:0] a;
                a = $urandom;
                if ($urandom % 4 != 0) a[31:28] = 4'hF;
                probe("R2 random", a);
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule